// File: doc/BRIEF.md
# External Bus Master Sequencer

This block turns single-beat read and write requests from an on-chip requester into transfers on a synchronous external memory bus. A request carries an address, a write flag, a transfer size, per-lane byte enables, write data, and a chip-select number with an enable bit. The sequencer drives the address, an active-low transfer-start pulse, the read/write line, the size code, active-low byte write enables, active-low chip selects and the write data. The burst-in-progress pin is held inactive.

Each chip select is set up by parameters. It is either internally timed, with its own wait count from 0 to 15, or externally terminated. A select that is internally timed ends its transfer on an acknowledge the block makes itself. All other transfers wait for an external acknowledge or error. Those inputs pass through a one-cycle register, so the bus stays driven for one cycle after the pins show them. The block enforces spacing between back-to-back transfers: one dead cycle after an internally timed end, and two after an externally ended one. When a write is followed at once by another access to the same select, that select stays low through the gap.

Top module: `ebus_seq`

## Requirements
- R1: During and after reset, with no request, `ebus_ts_n`, `ebus_bdip_n`, every `ebus_cs_n` and every `ebus_we_n` bit are 1, `ebus_doe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `ebus_ts_n` is low for exactly one cycle, which is the cycle after the request is accepted. From that cycle until the terminating cycle, `ebus_addr`, `ebus_rd_wr` (1 = read, 0 = write) and `ebus_tsiz` hold the request's values.
- R3: For an internally timed select with wait count W, the terminating cycle is W+1 cycles after the transfer-start cycle. `ebus_ta_n` and `ebus_tea_n` have no effect on such a transfer.
- R4: For an externally ended transfer, suppose `ebus_ta_n` or `ebus_tea_n` is low in the cycle k after transfer-start. Then the terminating cycle is k+1, and `ebus_addr` is still driven with the request address in that cycle.
- R5: After an internally timed termination, exactly one cycle without transfer-start separates it from the next transfer-start of a request that was already waiting.
- R6: After an external acknowledge or error, exactly two such gap cycles separate it from the next transfer-start.
- R7: If a write to an enabled select ends while a request to that same select (read or write) is already waiting, that select's `ebus_cs_n` stays low through the gap cycles.
- R8: For a request with its select enabled, only `ebus_cs_n[req_cs]` is low, from transfer-start through termination. For a request with its select disabled, all chip selects stay high. In all other gap cycles every chip select is high.
- R9: `ebus_we_n[i]` is low from transfer-start through termination only for a write with `req_be[i]`=1. All bits are high for reads and in gap cycles.
- R10: `ebus_doe` is 0 in the transfer-start cycle. For writes it is 1, with `ebus_dout` equal to the request data, from the next cycle through termination. It is 0 in gap cycles.
- R11: `rsp_valid` pulses for one cycle, in the cycle after the terminating cycle. For a read, `rsp_rdata` is `ebus_din` as sampled in the terminating cycle (internal) or in the acknowledge cycle (external). It is 0 for writes.
- R12: An error ending returns `rsp_err`=1 and `rsp_rdata`=0. If acknowledge and error are low together, error wins.
- R13: `req_ready` is 1 only in idle and in the last gap cycle. It is 0 from transfer-start through termination, and in the first of two gap cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code, passed to the bus |
| req_be | input | DW/8 | Byte-lane enables for writes |
| req_wdata | input | DW | Write data |
| req_cs_en | input | 1 | Request targets a chip select |
| req_cs | input | CSW | Chip-select number |
| rsp_valid | output | 1 | Completion strobe |
| rsp_err | output | 1 | Transfer ended on error |
| rsp_rdata | output | DW | Read data |
| ebus_addr | output | AW | Bus address |
| ebus_ts_n | output | 1 | Transfer start, active low |
| ebus_rd_wr | output | 1 | 1 = read, 0 = write |
| ebus_tsiz | output | 2 | Transfer size |
| ebus_bdip_n | output | 1 | Burst in progress, held high |
| ebus_we_n | output | DW/8 | Byte write enables, active low |
| ebus_cs_n | output | NCS | Chip selects, active low |
| ebus_dout | output | DW | Write data to the bus |
| ebus_doe | output | 1 | Write data output enable |
| ebus_din | input | DW | Read data from the bus |
| ebus_ta_n | input | 1 | External acknowledge, active low |
| ebus_tea_n | input | 1 | External error, active low |

## Verification
The bench builds the block with four chip selects. Selects 0, 1 and 2 are internally timed, with wait counts of 0, 1 and 3, and select 3 is externally terminated. Address and data are 24 and 32 bits wide. This covers the zero-wait and multi-wait cases of internal timing, acknowledge and error endings on a selected device and on an unselected access, and both gap lengths. It also reaches chip-select hold after a write, both behind a one-cycle gap and behind a two-cycle gap. Requests are queued back to back so that each new request is already waiting when the previous transfer ends.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GAP
  } ebus_state_e;
endpackage

// File: rtl/ebus_term_sync.sv
module ebus_term_sync #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ta_n,
  input  logic          tea_n,
  input  logic [DW-1:0] din,
  output logic          ack_q,
  output logic          err_q,
  output logic [DW-1:0] din_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      din_q <= '0;
    end else begin
      ack_q <= ~ta_n;
      err_q <= ~tea_n;
      din_q <= din;
    end
  end
endmodule

// File: rtl/ebus_wait_timer.sv
module ebus_wait_timer #(
  parameter int NCS = 4,
  parameter int WSW = 4,
  parameter int CSW = 2,
  parameter logic [NCS-1:0]     CS_INT  = '1,
  parameter logic [NCS*WSW-1:0] CS_WAIT = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           load_cs_en,
  input  logic [CSW-1:0] load_idx,
  input  logic           step,
  output logic           int_mode,
  output logic           expire
);
  logic [WSW-1:0] wait_tab [NCS];
  logic [NCS-1:0] int_tab;
  logic [WSW-1:0] cnt;

  for (genvar g = 0; g < NCS; g++) begin : g_tab
    assign wait_tab[g] = CS_WAIT[g*WSW +: WSW];
    assign int_tab[g]  = CS_INT[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_mode <= 1'b0;
      cnt      <= '0;
    end else if (load) begin
      int_mode <= load_cs_en && int_tab[load_idx];
      cnt      <= wait_tab[load_idx];
    end else if (step && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = int_mode && (cnt == '0);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step && cnt != '0) |=> (cnt == WSW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/ebus_cs_drv.sv
module ebus_cs_drv #(
  parameter int NCS = 4,
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set,
  input  logic           set_en,
  input  logic [CSW-1:0] set_idx,
  input  logic           term,
  input  logic           keep,
  input  logic           clear,
  output logic [NCS-1:0] cs_n
);
  logic [NCS-1:0] dec;

  for (genvar g = 0; g < NCS; g++) begin : g_dec
    assign dec[g] = (set_idx == CSW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= '1;
    end else if (set) begin
      cs_n <= set_en ? ~dec : '1;
    end else if ((term && !keep) || clear) begin
      cs_n <= '1;
    end
  end

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int NCS = 4,
  parameter int WSW = 4,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  parameter logic [NCS-1:0]     CS_INT  = 4'b0111,
  parameter logic [NCS*WSW-1:0] CS_WAIT = 16'h0310
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_cs_en,
  input  logic [CSW-1:0]    req_cs,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     ebus_addr,
  output logic              ebus_ts_n,
  output logic              ebus_rd_wr,
  output logic [1:0]        ebus_tsiz,
  output logic              ebus_bdip_n,
  output logic [DW/8-1:0]   ebus_we_n,
  output logic [NCS-1:0]    ebus_cs_n,
  output logic [DW-1:0]     ebus_dout,
  output logic              ebus_doe,
  input  logic [DW-1:0]     ebus_din,
  input  logic              ebus_ta_n,
  input  logic              ebus_tea_n
);
  localparam int NB = DW / 8;

  ebus_state_e    state;
  logic           gap_cnt;
  logic           cur_wr;
  logic           cur_cs_en;
  logic [CSW-1:0] cur_cs;

  logic           ack_q, err_q;
  logic [DW-1:0]  din_q;
  logic           tmr_int, tmr_expire;
  logic           accept, term, xfer_end, keep_cs, gap_done;

  ebus_term_sync #(.DW(DW)) i_sync (
    .clk(clk), .rst(rst), .ta_n(ebus_ta_n), .tea_n(ebus_tea_n),
    .din(ebus_din), .ack_q(ack_q), .err_q(err_q), .din_q(din_q)
  );

  ebus_wait_timer #(
    .NCS(NCS), .WSW(WSW), .CSW(CSW), .CS_INT(CS_INT), .CS_WAIT(CS_WAIT)
  ) i_timer (
    .clk(clk), .rst(rst), .load(accept), .load_cs_en(req_cs_en),
    .load_idx(req_cs), .step(state == ST_DATA),
    .int_mode(tmr_int), .expire(tmr_expire)
  );

  assign req_ready = (state == ST_IDLE) || (state == ST_GAP && gap_cnt == 1'b0);
  assign accept    = req_valid && req_ready;
  assign term      = tmr_int ? tmr_expire : (ack_q || err_q);
  assign xfer_end  = (state == ST_DATA) && term;
  assign keep_cs   = cur_wr && cur_cs_en && req_valid && req_cs_en && (req_cs == cur_cs);
  assign gap_done  = (state == ST_GAP) && (gap_cnt == 1'b0) && !accept;

  ebus_cs_drv #(.NCS(NCS), .CSW(CSW)) i_cs (
    .clk(clk), .rst(rst), .set(accept), .set_en(req_cs_en), .set_idx(req_cs),
    .term(xfer_end), .keep(keep_cs), .clear(gap_done), .cs_n(ebus_cs_n)
  );

  assign ebus_bdip_n = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      gap_cnt    <= 1'b0;
      cur_wr     <= 1'b0;
      cur_cs_en  <= 1'b0;
      cur_cs     <= '0;
      ebus_addr  <= '0;
      ebus_ts_n  <= 1'b1;
      ebus_rd_wr <= 1'b1;
      ebus_tsiz  <= '0;
      ebus_we_n  <= '1;
      ebus_dout  <= '0;
      ebus_doe   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      ebus_ts_n <= 1'b1;
      if (accept) begin
        state      <= ST_ADDR;
        ebus_ts_n  <= 1'b0;
        ebus_addr  <= req_addr;
        ebus_rd_wr <= ~req_write;
        ebus_tsiz  <= req_size;
        ebus_we_n  <= req_write ? ~req_be : {NB{1'b1}};
        ebus_dout  <= req_wdata;
        cur_wr     <= req_write;
        cur_cs_en  <= req_cs_en;
        cur_cs     <= req_cs;
      end else begin
        unique case (state)
          ST_ADDR: begin
            ebus_doe <= cur_wr;
            state    <= ST_DATA;
          end
          ST_DATA: begin
            if (term) begin
              ebus_we_n <= '1;
              ebus_doe  <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_err   <= !tmr_int && err_q;
              rsp_rdata <= (cur_wr || (!tmr_int && err_q)) ? '0 :
                           (tmr_int ? ebus_din : din_q);
              gap_cnt   <= !tmr_int;
              state     <= ST_GAP;
            end
          end
          ST_GAP: begin
            if (gap_cnt == 1'b0) state <= ST_IDLE;
            else gap_cnt <= 1'b0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  ts_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !ebus_ts_n |=> ebus_ts_n);
  // R5
  dead_int_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && tmr_int) |=> ebus_ts_n);
  // R6
  dead_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && !tmr_int) |=> ebus_ts_n ##1 ebus_ts_n);
  // R9
  we_read_chk: assert property (@(posedge clk) disable iff (rst)
    ebus_rd_wr |-> (&ebus_we_n));
  // R13
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ebus_ts_n |-> !req_ready);
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R10
  doe_ts_chk: assert property (@(posedge clk) disable iff (rst)
    !ebus_ts_n |-> !ebus_doe);
  // R8
  noncs_chk: assert property (@(posedge clk) disable iff (rst)
    (!ebus_ts_n && !cur_cs_en) |-> (&ebus_cs_n));
endmodule

// File: tb/test_ebus_seq.sv
module test_ebus_seq;
  localparam int AW = 24, DW = 32, NCS = 4, NB = 4;

  typedef struct {
    logic [AW-1:0] addr;
    bit            wr;
    logic [1:0]    size;
    logic [NB-1:0] be;
    logic [DW-1:0] wdata;
    bit            cs_en;
    int            cs;
    bit            ext;
    int            wt;
    int            ack_k;
    bit            err;
    bit            ta_too;
    bit            ign;
    logic [DW-1:0] rdata;
    bit            b2b;
    int            ts_cyc;
  } tx_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_cs_en = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0, req_cs = '0;
  logic [NB-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata, ebus_dout;
  logic [AW-1:0] ebus_addr;
  logic ebus_ts_n, ebus_rd_wr, ebus_bdip_n, ebus_doe;
  logic [1:0] ebus_tsiz;
  logic [NB-1:0] ebus_we_n;
  logic [NCS-1:0] ebus_cs_n;
  logic [DW-1:0] ebus_din = '0;
  logic ebus_ta_n = 1'b1, ebus_tea_n = 1'b1;

  ebus_seq i_ebus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_be(req_be), .req_wdata(req_wdata), .req_cs_en(req_cs_en),
    .req_cs(req_cs), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .ebus_addr(ebus_addr), .ebus_ts_n(ebus_ts_n),
    .ebus_rd_wr(ebus_rd_wr), .ebus_tsiz(ebus_tsiz), .ebus_bdip_n(ebus_bdip_n),
    .ebus_we_n(ebus_we_n), .ebus_cs_n(ebus_cs_n), .ebus_dout(ebus_dout),
    .ebus_doe(ebus_doe), .ebus_din(ebus_din), .ebus_ta_n(ebus_ta_n),
    .ebus_tea_n(ebus_tea_n)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0, outstanding = 0;
  tx_t exp_q[$];
  tx_t fly;
  bit  fly_v = 0;
  int  ack_at = -1, last_rsp = 0;
  bit  last_ext = 0, mon_on = 0;
  logic [AW-1:0] prev_addr = '0;

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic int wait_of(int cs);
    case (cs)
      1: return 1;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  // Scoreboard monitor and device model
  always @(negedge clk) begin
    if (mon_on) begin
      if (!ebus_ts_n) begin
        tx_t t;
        if (exp_q.size() == 0) chk(0, "R2", "unexpected ts", 0, 1);
        else begin
          t = exp_q.pop_front();
          t.ts_cyc = cyc;
          chk(ebus_addr == t.addr, "R2", "addr", ebus_addr, t.addr);
          chk(ebus_rd_wr == !t.wr, "R2", "rd_wr", ebus_rd_wr, !t.wr);
          chk(ebus_tsiz == t.size, "R2", "tsiz", ebus_tsiz, t.size);
          chk(ebus_we_n == (t.wr ? ~t.be : 4'hF), "R9", "we_n", ebus_we_n, t.wr ? ~t.be : 4'hF);
          chk(ebus_cs_n == (t.cs_en ? ~(4'b1 << t.cs) : 4'hF), "R8", "cs_n", ebus_cs_n,
              t.cs_en ? ~(4'b1 << t.cs) : 4'hF);
          chk(ebus_doe == 1'b0, "R10", "doe at ts", ebus_doe, 0);
          chk(req_ready == 1'b0, "R13", "ready at ts", req_ready, 0);
          if (t.b2b) begin
            if (last_ext) chk(cyc - last_rsp == 2, "R6", "ext gap", cyc - last_rsp, 2);
            else          chk(cyc - last_rsp == 1, "R5", "int gap", cyc - last_rsp, 1);
          end
          ebus_din = t.rdata;
          ack_at = t.ign ? cyc : (t.ext ? cyc + t.ack_k : -1);
          fly = t;
          fly_v = 1;
        end
      end
      if (fly_v && cyc == fly.ts_cyc + 1) begin
        chk(ebus_ts_n == 1'b1, "R2", "ts width", ebus_ts_n, 1);
        chk(ebus_doe == fly.wr, "R10", "doe", ebus_doe, fly.wr);
        if (fly.wr) chk(ebus_dout == fly.wdata, "R10", "dout", ebus_dout, fly.wdata);
      end
      if (rsp_valid) begin
        if (!fly_v) chk(0, "R11", "unexpected rsp", 1, 0);
        else begin
          tx_t t;
          bit hold;
          int ecyc;
          t = fly;
          fly_v = 0;
          ecyc = t.ext ? t.ts_cyc + t.ack_k + 2 : t.ts_cyc + t.wt + 2;
          chk(cyc == ecyc, t.ext ? "R4" : "R3", "term timing", cyc, ecyc);
          chk(rsp_err == (t.ext && t.err), "R12", "rsp_err", rsp_err, t.ext && t.err);
          chk(rsp_rdata == ((t.wr || (t.ext && t.err)) ? 32'h0 : t.rdata), "R11", "rdata",
              rsp_rdata, (t.wr || (t.ext && t.err)) ? 32'h0 : t.rdata);
          if (t.ext) chk(prev_addr == t.addr, "R4", "addr held", prev_addr, t.addr);
          hold = t.wr && t.cs_en && exp_q.size() > 0 && exp_q[0].cs_en && exp_q[0].cs == t.cs;
          chk(ebus_cs_n == (hold ? ~(4'b1 << t.cs) : 4'hF), hold ? "R7" : "R8", "gap cs_n",
              ebus_cs_n, hold ? ~(4'b1 << t.cs) : 4'hF);
          chk(ebus_we_n == 4'hF, "R9", "gap we_n", ebus_we_n, 4'hF);
          chk(ebus_doe == 1'b0, "R10", "gap doe", ebus_doe, 0);
          chk(req_ready == !t.ext, "R13", "gap ready", req_ready, !t.ext);
          last_rsp = cyc;
          last_ext = t.ext;
          outstanding--;
        end
      end
      ebus_ta_n  = !(ack_at == cyc && fly_v && (!fly.err || fly.ta_too || fly.ign));
      ebus_tea_n = !(ack_at == cyc && fly_v && fly.err && !fly.ign);
      prev_addr = ebus_addr;
    end
  end

  task automatic issue(input logic [AW-1:0] a, input bit wr, input logic [NB-1:0] be,
                       input logic [DW-1:0] d, input bit cen, input int cs, input int k,
                       input bit err, input bit tat, input bit ign);
    tx_t t;
    t.addr = a; t.wr = wr; t.size = 2'(cs); t.be = be; t.wdata = d;
    t.cs_en = cen; t.cs = cs; t.ext = !cen || cs == 3; t.wt = wait_of(cs);
    t.ack_k = k; t.err = err; t.ta_too = tat; t.ign = ign;
    t.rdata = {a[15:0], 16'hC0DE}; t.b2b = outstanding > 0; t.ts_cyc = 0;
    exp_q.push_back(t);
    outstanding++;
    req_addr = a; req_write = wr; req_size = 2'(cs); req_be = be;
    req_wdata = d; req_cs_en = cen; req_cs = 2'(cs); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (outstanding > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held in reset
    chk(ebus_ts_n && ebus_bdip_n && &ebus_cs_n && &ebus_we_n && !ebus_doe && !rsp_valid,
        "R1", "pins in reset", {ebus_ts_n, ebus_cs_n, ebus_we_n}, 9'h1FF);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(ebus_ts_n && &ebus_cs_n && !ebus_doe, "R1", "idle pins", ebus_ts_n, 1);
    mon_on = 1;
    // R3 zero-wait read, single
    issue(24'h000100, 0, 4'h0, 32'h0, 1, 0, 0, 0, 0, 0);
    drain();
    // R7 write-write and write-read on select 1, then read-read, then other select
    issue(24'h001000, 1, 4'h5, 32'hA5A5_0001, 1, 1, 0, 0, 0, 0);
    issue(24'h001004, 1, 4'hF, 32'hA5A5_0002, 1, 1, 0, 0, 0, 0);
    issue(24'h001008, 0, 4'h0, 32'h0, 1, 1, 0, 0, 0, 0);
    issue(24'h00100C, 0, 4'h0, 32'h0, 1, 1, 0, 0, 0, 0);
    issue(24'h002000, 1, 4'h3, 32'h1234_5678, 1, 2, 0, 0, 0, 0);
    issue(24'h002004, 1, 4'h8, 32'h8765_4321, 1, 0, 0, 0, 0, 0);
    issue(24'h003000, 0, 4'h0, 32'h0, 1, 1, 0, 0, 0, 0);
    drain();
    // R4 R6 externally terminated select, hold after write across two gaps
    issue(24'h030000, 0, 4'h0, 32'h0, 1, 3, 2, 0, 0, 0);
    issue(24'h030004, 1, 4'hC, 32'hDEAD_0003, 1, 3, 1, 0, 0, 0);
    issue(24'h030008, 1, 4'h1, 32'hDEAD_0004, 1, 3, 3, 0, 0, 0);
    issue(24'h03000C, 0, 4'h0, 32'h0, 1, 3, 1, 0, 0, 0);
    drain();
    // R12 unselected accesses, error and error-with-acknowledge
    issue(24'h040000, 0, 4'h0, 32'h0, 0, 0, 3, 0, 0, 0);
    issue(24'h040004, 1, 4'hF, 32'hBEEF_0005, 0, 0, 1, 1, 0, 0);
    issue(24'h040008, 0, 4'h0, 32'h0, 0, 2, 1, 1, 1, 0);
    issue(24'h04000C, 0, 4'h0, 32'h0, 1, 3, 2, 1, 0, 0);
    drain();
    // R3 early external acknowledge ignored on an internally timed select
    issue(24'h050000, 0, 4'h0, 32'h0, 1, 1, 0, 0, 0, 1);
    issue(24'h050004, 0, 4'h0, 32'h0, 1, 2, 0, 0, 0, 1);
    drain();
    chk(exp_q.size() == 0 && outstanding == 0, "R11", "all responses seen", outstanding, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule